// File: doc/BRIEF.md
# Per-Core Local Tick Timer

This block is one core's private event timer, built from two stages in a chain. The first stage is a tick prescaler. It divides the input clock by a programmable divisor plus one. The second stage is a 31-bit interrupt down-counter. It counts those ticks and flags an expiry when its count runs out.

In interval mode the down-counter reloads itself from its buffer and keeps firing. Without interval mode it fires once and then parks at zero, and software stops it. Software programs the timer through a small word-addressed register bus. Writes to the divisor, the count buffer and the control word are committed a fixed number of cycles after the bus write. Each of these three has its own sticky write-status bit, which announces the commit.

A second-level interrupt is raised when the pending status is set and the enable is on. Software clears pending status and write status by writing ones.

Top module: `local_tick_timer`

## Requirements
- R1: After reset every readable register (addresses 0 to 6) reads zero and `irq` is low.
- R2: A bus write to the control word (address 0), the divisor (address 1) or the count buffer (address 2) becomes visible on readback three clock edges after the write edge, not earlier. In that same edge the matching write-status bit sets: bit 0 for the divisor, bit 1 for the count buffer and bit 3 for the control word. Write status reads at address 5.
- R3: Writing the write-status register clears each bit that is written as 1 and leaves each bit that is written as 0.
- R4: While the control word's run bit (bit 0) is set, a tick occurs every divisor+1 clocks. With the count-run bit (bit 1) also set, the first expiry after a control commit makes `irq` visible count*(divisor+1) edges after that commit.
- R5: A count-buffer write whose bit 31 is 0 changes neither the buffer readback (address 2) nor the live count (address 6).
- R6: A count loaded with bit 31 set is taken from bits 30:0. A value below 15 is raised to 15, and both the buffer and the live count take the result.
- R7: With interval mode (control bit 2) set, the counter reloads from its buffer on each expiry. Successive expiries are count*(divisor+1) clocks apart.
- R8: With interval mode clear, the counter expires once and stays at zero, and no further expiry follows. The control word keeps its count-run bit set until software writes it.
- R9: Clearing both the run bit and the count-run bit freezes the live count and prevents any further expiry.
- R10: `irq` is the pending bit (address 4, bit 0) ANDed with the enable bit (address 3, bit 0). An enable write takes effect at its own write edge.
- R11: The pending bit sets at the edge that ends the expiring cycle. Writing 1 to bit 0 of address 4 clears it, and writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench counts every result from the write edge. A committed register reads back after exactly three edges, and its write-status bit is checked clear at edge two and set at edge three. Enable and W1C writes act at their own edge.

The first interrupt is due count*(divisor+1) edges after the control commit. Later interval interrupts are due count*(divisor+1) edges after the previous one.

A monitor stamps each rising `irq` two nanoseconds after the clock edge with a running edge count. The bench compares these stamps to times computed from the programmed values. Register reads are taken half a period after an edge.

// File: rtl/ltt_pkg.sv
package ltt_pkg;

   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL  = 3'd0,
      A_TICKB = 3'd1,
      A_ICNTB = 3'd2,
      A_IEN   = 3'd3,
      A_ISTAT = 3'd4,
      A_WSTAT = 3'd5,
      A_LIVE  = 3'd6
   } reg_addr_e;

   localparam int unsigned WS_TICK = 0;
   localparam int unsigned WS_ICNT = 1;
   localparam int unsigned WS_CTRL = 3;
   localparam int unsigned WS_W    = 4;

   typedef struct packed {
      logic ivl;   // bit 2: reload on expiry
      logic irun;  // bit 1: interrupt counter enable
      logic run;   // bit 0: prescaler enable
   } ctrl_t;

endpackage

// File: rtl/ltt_commit_pipe.sv
module ltt_commit_pipe #(
   parameter int unsigned LAT = 3,
   parameter int unsigned AW  = 3,
   parameter int unsigned DW  = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_data,
   output logic          out_vld,
   output logic [AW-1:0] out_addr,
   output logic [DW-1:0] out_data
);

   if (LAT < 1) begin : g_bad_lat
      $error("ltt_commit_pipe: LAT must be at least 1");
   end

   for (genvar s = 0; s < LAT; s++) begin : g_stage
      logic          vld;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld  <= 1'b0;
               addr <= '0;
               data <= '0;
            end else begin
               vld  <= in_vld;
               addr <= in_addr;
               data <= in_data;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld  <= 1'b0;
               addr <= '0;
               data <= '0;
            end else begin
               vld  <= g_stage[s-1].vld;
               addr <= g_stage[s-1].addr;
               data <= g_stage[s-1].data;
            end
         end
      end
   end

   assign out_vld  = g_stage[LAT-1].vld;
   assign out_addr = g_stage[LAT-1].addr;
   assign out_data = g_stage[LAT-1].data;

endmodule

// File: rtl/ltt_prescaler.sv
module ltt_prescaler #(
   parameter int unsigned TICK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [TICK_W-1:0] div_i,
   output logic              tick_o
);

   if (TICK_W < 1) begin : g_bad_w
      $error("ltt_prescaler: TICK_W must be at least 1");
   end

   logic [TICK_W-1:0] pcnt_q;

   // wrap on >= so a divisor lowered mid-count cannot be skipped over
   assign tick_o = run_i && (pcnt_q >= div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt_q <= '0;
      else if (!run_i)  pcnt_q <= '0;
      else if (tick_o)  pcnt_q <= '0;
      else              pcnt_q <= pcnt_q + 1'b1;
   end

   assert_tick_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (pcnt_q == '0));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (pcnt_q == '0));

endmodule

// File: rtl/ltt_irq_counter.sv
module ltt_irq_counter #(
   parameter int unsigned CNT_W   = 31,
   parameter int unsigned CNT_MIN = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             ivl_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] buf_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);

   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_w
      $error("ltt_irq_counter: CNT_W must lie in 2..31");
   end
   if (CNT_MIN < 1) begin : g_bad_min
      $error("ltt_irq_counter: CNT_MIN must be at least 1");
   end

   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(CNT_MIN);
   localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

   logic [CNT_W-1:0] buf_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_eff;
   logic             step;

   assign load_eff = (load_val_i < MIN_V) ? MIN_V : load_val_i;
   assign step     = run_i && tick_i && !load_i && (cnt_q != '0);
   assign expire_o = step && (cnt_q == ONE_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         buf_q <= load_eff;
         cnt_q <= load_eff;
      end else if (step) begin
         if (expire_o && ivl_i) cnt_q <= buf_q;
         else                   cnt_q <= cnt_q - ONE_V;
      end
   end

   assign buf_o = buf_q;
   assign cnt_o = cnt_q;

   assert_cnt_le_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= buf_q);

   assert_load_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (buf_q >= MIN_V));

   assert_noflag_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(buf_q));

   assert_oneshot_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

endmodule

// File: rtl/local_tick_timer.sv
module local_tick_timer
   import ltt_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned TICK_W     = 32,
   parameter int unsigned CNT_W      = 31,
   parameter int unsigned CNT_MIN    = 15,
   parameter int unsigned COMMIT_LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);

   localparam int unsigned FLAG_BIT = CNT_W;

   if (CNT_W + 1 > DATA_W) begin : g_bad_cnt
      $error("local_tick_timer: count plus update flag exceeds DATA_W");
   end
   if (TICK_W > DATA_W) begin : g_bad_tick
      $error("local_tick_timer: TICK_W exceeds DATA_W");
   end
   if (COMMIT_LAT < 1) begin : g_bad_lat
      $error("local_tick_timer: COMMIT_LAT must be at least 1");
   end

   // ---------------- delayed-commit path ----------------
   logic              pipe_in;
   logic              commit_vld;
   logic [ADDR_W-1:0] commit_addr;
   logic [DATA_W-1:0] commit_data;

   assign pipe_in = reg_we && (reg_addr == A_CTRL || reg_addr == A_TICKB ||
                               reg_addr == A_ICNTB);

   ltt_commit_pipe #(
      .LAT (COMMIT_LAT),
      .AW  (ADDR_W),
      .DW  (DATA_W)
   ) u_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (pipe_in),
      .in_addr  (reg_addr),
      .in_data  (reg_wdata),
      .out_vld  (commit_vld),
      .out_addr (commit_addr),
      .out_data (commit_data)
   );

   logic c_ctrl, c_tick, c_icnt;
   assign c_ctrl = commit_vld && (commit_addr == A_CTRL);
   assign c_tick = commit_vld && (commit_addr == A_TICKB);
   assign c_icnt = commit_vld && (commit_addr == A_ICNTB);

   // ---------------- committed registers ----------------
   ctrl_t             ctrl_q;
   logic [TICK_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         div_q  <= '0;
      end else begin
         if (c_ctrl) ctrl_q <= ctrl_t'(commit_data[2:0]);
         if (c_tick) div_q  <= commit_data[TICK_W-1:0];
      end
   end

   // ---------------- timer stages ----------------
   logic             tick;
   logic             expire;
   logic [CNT_W-1:0] cnt_buf;
   logic [CNT_W-1:0] cnt_live;
   logic             cnt_load;

   assign cnt_load = c_icnt && commit_data[FLAG_BIT];

   ltt_prescaler #(
      .TICK_W (TICK_W)
   ) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (ctrl_q.run),
      .div_i  (div_q),
      .tick_o (tick)
   );

   ltt_irq_counter #(
      .CNT_W   (CNT_W),
      .CNT_MIN (CNT_MIN)
   ) u_icnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .run_i      (ctrl_q.irun),
      .ivl_i      (ctrl_q.ivl),
      .load_i     (cnt_load),
      .load_val_i (commit_data[CNT_W-1:0]),
      .buf_o      (cnt_buf),
      .cnt_o      (cnt_live),
      .expire_o   (expire)
   );

   // ---------------- immediate registers ----------------
   logic            ien_q;
   logic            pend_q;
   logic [WS_W-1:0] wstat_q;
   logic [WS_W-1:0] ws_set;
   logic            wr_ien, wr_istat, wr_wstat;

   assign wr_ien   = reg_we && (reg_addr == A_IEN);
   assign wr_istat = reg_we && (reg_addr == A_ISTAT);
   assign wr_wstat = reg_we && (reg_addr == A_WSTAT);

   always_comb begin
      ws_set          = '0;
      ws_set[WS_TICK] = c_tick;
      ws_set[WS_ICNT] = c_icnt;
      ws_set[WS_CTRL] = c_ctrl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q   <= 1'b0;
         pend_q  <= 1'b0;
         wstat_q <= '0;
      end else begin
         if (wr_ien) ien_q <= reg_wdata[0];
         // a set in the same edge wins over a clear
         pend_q  <= expire | (pend_q & ~(wr_istat & reg_wdata[0]));
         wstat_q <= ws_set | (wstat_q & ~(wr_wstat ? reg_wdata[WS_W-1:0] : '0));
      end
   end

   assign irq = pend_q & ien_q;

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:  reg_rdata[2:0]        = ctrl_q;
         A_TICKB: reg_rdata[TICK_W-1:0] = div_q;
         A_ICNTB: reg_rdata[CNT_W-1:0]  = cnt_buf;
         A_IEN:   reg_rdata[0]          = ien_q;
         A_ISTAT: reg_rdata[0]          = pend_q;
         A_WSTAT: reg_rdata[WS_W-1:0]   = wstat_q;
         A_LIVE:  reg_rdata[CNT_W-1:0]  = cnt_live;
         default: reg_rdata             = '0;
      endcase
   end

   assert_pend_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(expire));

   assert_wstat_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wstat_q[WS_CTRL]) |-> $past(commit_vld && commit_addr == A_CTRL));

   assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_ien) && !$past(ien_q)) |-> !irq);

endmodule

// File: tb/test_local_tick_timer.sv
module test_local_tick_timer;
   import ltt_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int nr     = 0;
   int rise_t [128];
   logic irq_prev = 1'b0;

   local_tick_timer i_local_tick_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   always #5 clk = ~clk;

   // edge stamp monitor for rising irq
   always @(posedge clk) begin
      #2;
      cyc++;
      if (irq === 1'b1 && irq_prev === 1'b0) begin
         if (nr < 128) rise_t[nr] = cyc;
         nr++;
      end
      irq_prev = irq;
   end

   function automatic int eff(int n);
      return (n < 15) ? 15 : n;
   endfunction

   function automatic int due(int n, int d);
      return eff(n) * (d + 1);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d, output int t);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
      t = cyc;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_rise(int target, int limit);
      for (int i = 0; i < limit && nr < target; i++) @(negedge clk);
   endtask

   task automatic chk_commit(logic [2:0] a, logic [31:0] d, logic [31:0] oldv,
                             logic [31:0] newv, int wsb, string req);
      int t; logic [31:0] v;
      wr(A_WSTAT, 32'hB, t);
      wr(a, d, t);
      rd(a, v); chk(req, v, oldv);
      @(negedge clk); rd(a, v); chk(req, v, oldv);
      @(negedge clk); rd(a, v); chk(req, v, oldv);
      rd(A_WSTAT, v); chk(req, {31'b0, v[wsb]}, 32'd0);
      @(negedge clk); rd(a, v); chk(req, v, newv);
      rd(A_WSTAT, v); chk(req, {31'b0, v[wsb]}, 32'd1);
   endtask

   task automatic start_run(int d, int n, logic ivl, output int t);
      int tt;
      wr(A_TICKB, d, tt);
      wr(A_ICNTB, 32'h8000_0000 | n, tt);
      wr(A_CTRL, ivl ? 32'd7 : 32'd3, t);
   endtask

   task automatic stop_run();
      int t;
      wr(A_CTRL, 32'd0, t);
      idle(4);
      wr(A_ISTAT, 32'd1, t);
      wr(A_WSTAT, 32'hB, t);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (all requirements): actual hung, expected finish");
      summary();
      $finish;
   end

   initial begin
      int t, base, d, n;
      logic [31:0] v, v2;
      void'($urandom(32'd4242));
      for (int i = 0; i < 128; i++) rise_t[i] = 0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 irq", {31'b0, irq}, 32'd0);
      for (int a = 0; a < 7; a++) begin
         rd(3'(a), v); chk("R1 readback", v, 32'd0);
      end

      // R2: commit latency and write-status bit
      chk_commit(A_TICKB, 32'd7, 32'd0, 32'd7, WS_TICK, "R2 divisor");
      for (int k = 0; k < 4; k++) begin
         v2 = $urandom % 256;
         rd(A_TICKB, v);
         chk_commit(A_TICKB, v2, v, v2, WS_TICK, "R2 random divisor");
      end

      // R3: write-status W1C
      wr(A_TICKB, 32'd3, t); idle(4);
      wr(A_WSTAT, 32'd0, t); rd(A_WSTAT, v); chk("R3 write 0 keeps", v, 32'd1);
      wr(A_WSTAT, 32'hB, t); rd(A_WSTAT, v); chk("R3 write 1 clears", v, 32'd0);

      // R6: small count clamped, R2 bit 1
      chk_commit(A_ICNTB, 32'h8000_0005, 32'd0, 32'd15, WS_ICNT, "R6 clamp");
      rd(A_LIVE, v); chk("R6 live", v, 32'd15);

      // R5: no update flag
      wr(A_ICNTB, 32'h0000_0064, t); idle(4);
      rd(A_ICNTB, v); chk("R5 buffer kept", v, 32'd15);
      rd(A_LIVE, v);  chk("R5 live kept", v, 32'd15);
      rd(A_WSTAT, v); chk("R5 status set", {31'b0, v[WS_ICNT]}, 32'd1);
      wr(A_WSTAT, 32'hB, t);

      // R8 / R4: one-shot with enable on
      wr(A_IEN, 32'd1, t);
      base = nr;
      start_run(1, 16, 1'b0, t);
      wait_rise(base + 1, 400);
      chk("R4 first expiry", rise_t[base], t + 3 + due(16, 1));
      wr(A_ISTAT, 32'd1, t);
      idle(3 * due(16, 1));
      chk("R8 single expiry", nr, base + 1);
      rd(A_CTRL, v); chk("R8 start bit kept", v, 32'd3);
      rd(A_LIVE, v); chk("R8 parked", v, 32'd0);
      stop_run();

      // R6 timing: count 5 behaves as 15
      base = nr;
      start_run(0, 5, 1'b0, t);
      wait_rise(base + 1, 200);
      chk("R6 clamped timing", rise_t[base], t + 3 + due(5, 0));
      stop_run();

      // R7 / R4: random interval runs
      for (int k = 0; k < 8; k++) begin
         d = $urandom % 4;
         n = 15 + ($urandom % 30);
         base = nr;
         start_run(d, n, 1'b1, t);
         wait_rise(base + 1, 600);
         chk("R4 random first", rise_t[base], t + 3 + due(n, d));
         wr(A_ISTAT, 32'd1, t);
         wait_rise(base + 2, 600);
         chk("R7 reload period", rise_t[base + 1] - rise_t[base], due(n, d));
         wr(A_ISTAT, 32'd1, t);
         wait_rise(base + 3, 600);
         chk("R7 reload period", rise_t[base + 2] - rise_t[base + 1], due(n, d));
         stop_run();
      end

      // R9: stop freezes the count
      base = nr;
      start_run(1, 20, 1'b1, t);
      idle(10);
      wr(A_CTRL, 32'd0, t);
      idle(4);
      rd(A_LIVE, v);
      idle(100);
      rd(A_LIVE, v2);
      chk("R9 count frozen", v2, v);
      chk("R9 no expiry", nr, base);
      stop_run();

      // R10 / R11: enable gating and pending W1C
      wr(A_IEN, 32'd0, t);
      start_run(0, 15, 1'b0, t);
      idle(30);
      chk("R10 masked", {31'b0, irq}, 32'd0);
      rd(A_ISTAT, v); chk("R11 pending set", v, 32'd1);
      wr(A_IEN, 32'd1, t);
      chk("R10 unmasked", {31'b0, irq}, 32'd1);
      wr(A_ISTAT, 32'd0, t);
      chk("R11 write 0 keeps", {31'b0, irq}, 32'd1);
      wr(A_ISTAT, 32'd1, t);
      chk("R11 cleared", {31'b0, irq}, 32'd0);
      rd(A_ISTAT, v); chk("R11 status clear", v, 32'd0);
      stop_run();

      summary();
      $finish;
   end

endmodule